// File: doc/BRIEF.md
# Dual Down-Counting Timer with Shared Interrupt

This block holds two identical down-counting timers. Software reaches them through a word-wide register interface. Each timer has three registers:

- a divider register that is only stored when written;
- a control register that takes an operation and a tick-source code;
- a live count register.

A timer advances only on the cycles where its selected tick-enable input is high. The tick enables come from clock-rate generators outside the block. When a running timer expires, it reloads and keeps running. The expiry also latches a bit in a shared raw interrupt register. A mask register gates the raw bits. An acknowledge register clears raw bits when they are written as one. A single level interrupt line reports whether any masked bit is set. A free-running time counter can also be read.

Writes take one cycle: `wr_en` with `wr_addr` and `wr_data`. Reads are combinational from `rd_addr`. The block applies no back-pressure, so every write strobe is taken in the cycle it is presented.

Register offsets (byte addresses):

| Offset | Register |
|---|---|
| 0x00 | timer 0 divider |
| 0x04 | timer 0 control |
| 0x08 | timer 0 count |
| 0x10 | timer 1 divider |
| 0x14 | timer 1 control |
| 0x18 | timer 1 count |
| 0x20 | time |
| 0x40 | mask |
| 0x44 | acknowledge |
| 0x50 | raw |
| 0x54 | masked |

Top module: `dual_tick_timer`

## Requirements
- R1: Control bits [1:0] are an operation code. Code 0 copies the divider into the count and stops the timer. Code 1 stops the timer and keeps its count. Code 2 starts the timer from its present count. Each takes effect at the clock edge that captures the write.
- R2: A control write with operation code 3 is discarded as a whole. Operation, source, running state and count stay as they were, and the control readback is unchanged.
- R3: Control bits [4:2] choose the tick source. Codes 4, 5, 6 and 7 select `tick_en[0]`, `[1]`, `[2]` and `[3]`. Codes 0 to 3 select no source, so the timer never advances. Ticks on lanes that are not selected have no effect.
- R4: On each selected tick a running timer whose count is 2 or more decrements by one. If the count is 1 or 0, the timer expires instead, reloads the active divider and stays running. So a divider D of 1 or more expires every D ticks, and a divider of 0 expires on every tick.
- R5: A divider write only stores the value. The active divider, used by both load and reload, is taken from the stored value at the next accepted control write.
- R6: Expiry of timer 0 sets raw bit 0, and expiry of timer 1 sets raw bit 1. The raw register reads at 0x50.
- R7: Offset 0x54 reads the raw bits ANDed with the mask register, and offset 0x40 reads the mask, bits [1:0].
- R8: Writing 0x44 clears each raw bit written as 1. The value does not persist, and 0x44 reads zero. If an expiry and an acknowledge hit the same bit in one cycle, the bit ends set.
- R9: `irq_o` is high exactly when any masked bit is set. It follows a mask write, acknowledge or expiry from the next clock edge.
- R10: The time register at 0x20 advances by one every clock cycle.
- R11: Writes to unused offsets change no register, and reads of unused offsets return zero.
- R12: Reset stops both timers, clears counts, control, raw and mask, and holds `irq_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | ADDR_W | Write byte offset |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_data | output | DATA_W | Combinational read data |
| tick_en | input | 4 | Rate enables for source codes 4 to 7 |
| irq_o | output | 1 | Level interrupt, any masked raw bit |

## Verification
A wrong count or a wrong reload value shows at the count register on the very next read. It also shows as a raw bit that arrives one selected tick early or late. The bench sweeps every divider from 1 to 4 against every source code for both timers to catch exactly that. A stale active divider, or an operation-3 write that leaked through, changes a count readback within one tick. A lost or stuck raw bit shows in the raw, masked and `irq_o` values one edge after the event or write that should have moved it. A misdecoded offset shows at once as a non-zero unused read or as a changed mask.

// File: rtl/dtt_pkg.sv
package dtt_pkg;
  localparam int OP_W     = 2;
  localparam int SRC_W    = 3;
  localparam int CTRL_W   = OP_W + SRC_W;
  localparam int NUM_TMR  = 2;
  localparam int NUM_LANE = 4;
  localparam int SRC_FIRST = 4;

  localparam int OFF_DIV    = 'h00;
  localparam int OFF_CTRL   = 'h04;
  localparam int OFF_CNT    = 'h08;
  localparam int TMR_STRIDE = 'h10;
  localparam int ADR_TIME   = 'h20;
  localparam int ADR_MASK   = 'h40;
  localparam int ADR_ACK    = 'h44;
  localparam int ADR_RAW    = 'h50;
  localparam int ADR_MASKED = 'h54;

  typedef enum logic [OP_W-1:0] {
    OP_LOAD = 2'd0,
    OP_HOLD = 2'd1,
    OP_RUN  = 2'd2,
    OP_BAD  = 2'd3
  } op_e;
endpackage

// File: rtl/dtt_timer.sv
module dtt_timer
  import dtt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctrl_we,
  input  logic [CTRL_W-1:0]   ctrl_d,
  input  logic [CNT_W-1:0]    div_d,
  input  logic [NUM_LANE-1:0] tick_en,
  output logic [CNT_W-1:0]    count_o,
  output logic [CTRL_W-1:0]   ctrl_o,
  output logic                run_o,
  output logic                expire_o
);
  logic [CNT_W-1:0] count_q, reload_q;
  logic [SRC_W-1:0] src_q;
  op_e              op_q, op_in;
  logic             run_q, accept, tick_sel, at_end;

  assign op_in  = op_e'(ctrl_d[OP_W-1:0]);
  assign accept = ctrl_we && (op_in != OP_BAD);
  assign at_end = (count_q <= CNT_W'(1));

  // lane l answers to source code SRC_FIRST + l; other codes never tick
  always_comb begin
    tick_sel = 1'b0;
    for (int l = 0; l < NUM_LANE; l++) begin
      if (src_q == SRC_W'(SRC_FIRST + l)) tick_sel = tick_en[l];
    end
  end

  // a control write in the same cycle takes precedence over the tick
  assign expire_o = run_q && tick_sel && !accept && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q  <= '0;
      reload_q <= '0;
      src_q    <= '0;
      op_q     <= OP_LOAD;
      run_q    <= 1'b0;
    end else if (accept) begin
      src_q    <= ctrl_d[CTRL_W-1:OP_W];
      op_q     <= op_in;
      reload_q <= div_d;
      case (op_in)
        OP_LOAD: begin
          count_q <= div_d;
          run_q   <= 1'b0;
        end
        OP_HOLD: run_q <= 1'b0;
        OP_RUN:  run_q <= 1'b1;
        default: ;
      endcase
    end else if (run_q && tick_sel) begin
      count_q <= at_end ? reload_q : count_q - CNT_W'(1);
    end
  end

  assign count_o = count_q;
  assign ctrl_o  = {src_q, op_q};
  assign run_o   = run_q;
endmodule

// File: rtl/dtt_irq.sv
module dtt_irq #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         mask_we,
  input  logic [N-1:0] mask_d,
  input  logic         ack_we,
  input  logic [N-1:0] ack_d,
  output logic [N-1:0] raw_o,
  output logic [N-1:0] mask_o,
  output logic         irq_o
);
  logic [N-1:0] raw_q, mask_q, clr;

  assign clr = ack_we ? ack_d : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q <= (raw_q & ~clr) | set_i;  // set beats acknowledge
      if (mask_we) mask_q <= mask_d;
    end
  end

  assign raw_o  = raw_q;
  assign mask_o = mask_q;
  assign irq_o  = |(raw_q & mask_q);
endmodule

// File: rtl/dtt_timebase.sv
module dtt_timebase #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] time_o
);
  logic [W-1:0] time_q;

  always_ff @(posedge clk) begin
    if (!rst_n) time_q <= '0;
    else        time_q <= time_q + W'(1);
  end

  assign time_o = time_q;
endmodule

// File: rtl/dual_tick_timer.sv
module dual_tick_timer
  import dtt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 32,
  parameter int TIME_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [DATA_W-1:0]   rd_data,
  input  logic [NUM_LANE-1:0] tick_en,
  output logic                irq_o
);
  logic [NUM_TMR-1:0][CNT_W-1:0]  div_q;
  logic [NUM_TMR-1:0][CNT_W-1:0]  tmr_cnt;
  logic [NUM_TMR-1:0][CTRL_W-1:0] tmr_ctrl;
  logic [NUM_TMR-1:0]             tmr_run, tmr_exp;
  logic [NUM_TMR-1:0]             raw_q, mask_q;
  logic [TIME_W-1:0]              time_q;
  logic                           mask_we, ack_we;

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    logic div_we, ctrl_we;
    assign div_we  = wr_en && (wr_addr == ADDR_W'(i*TMR_STRIDE + OFF_DIV));
    assign ctrl_we = wr_en && (wr_addr == ADDR_W'(i*TMR_STRIDE + OFF_CTRL));

    always_ff @(posedge clk) begin
      if (!rst_n)      div_q[i] <= '0;
      else if (div_we) div_q[i] <= wr_data[CNT_W-1:0];
    end

    dtt_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctrl_we  (ctrl_we),
      .ctrl_d   (wr_data[CTRL_W-1:0]),
      .div_d    (div_q[i]),
      .tick_en  (tick_en),
      .count_o  (tmr_cnt[i]),
      .ctrl_o   (tmr_ctrl[i]),
      .run_o    (tmr_run[i]),
      .expire_o (tmr_exp[i])
    );
  end

  assign mask_we = wr_en && (wr_addr == ADDR_W'(ADR_MASK));
  assign ack_we  = wr_en && (wr_addr == ADDR_W'(ADR_ACK));

  dtt_irq #(.N(NUM_TMR)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (tmr_exp),
    .mask_we (mask_we),
    .mask_d  (wr_data[NUM_TMR-1:0]),
    .ack_we  (ack_we),
    .ack_d   (wr_data[NUM_TMR-1:0]),
    .raw_o   (raw_q),
    .mask_o  (mask_q),
    .irq_o   (irq_o)
  );

  dtt_timebase #(.W(TIME_W)) u_time (
    .clk    (clk),
    .rst_n  (rst_n),
    .time_o (time_q)
  );

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_TMR; i++) begin
      if (rd_addr == ADDR_W'(i*TMR_STRIDE + OFF_DIV))  rd_data = DATA_W'(div_q[i]);
      if (rd_addr == ADDR_W'(i*TMR_STRIDE + OFF_CTRL)) rd_data = DATA_W'(tmr_ctrl[i]);
      if (rd_addr == ADDR_W'(i*TMR_STRIDE + OFF_CNT))  rd_data = DATA_W'(tmr_cnt[i]);
    end
    if (rd_addr == ADDR_W'(ADR_TIME))   rd_data = DATA_W'(time_q);
    if (rd_addr == ADDR_W'(ADR_MASK))   rd_data = DATA_W'(mask_q);
    if (rd_addr == ADDR_W'(ADR_RAW))    rd_data = DATA_W'(raw_q);
    if (rd_addr == ADDR_W'(ADR_MASKED)) rd_data = DATA_W'(raw_q & mask_q);
  end
endmodule

// File: rtl/dtt_chk.sv
module dtt_chk
  import dtt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int TIME_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic [DATA_W-1:0]  wr_data,
  input logic               irq_o,
  input logic [NUM_TMR-1:0] raw_q,
  input logic [NUM_TMR-1:0] mask_q,
  input logic [NUM_TMR-1:0] tmr_exp,
  input logic [NUM_TMR-1:0] tmr_run,
  input logic [TIME_W-1:0]  time_q
);
  assert_expiry_sets_raw_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_exp[0] |=> raw_q[0]);

  assert_expiry_needs_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_exp != '0) |-> ((tmr_exp & ~tmr_run) == '0));

  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(ADR_ACK) && wr_data[1] && !tmr_exp[1]) |=> !raw_q[1]);

  assert_bad_op_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(OFF_CTRL) && wr_data[1:0] == 2'b11) |=> (tmr_run[0] == $past(tmr_run[0])));

  assert_quiet_when_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq_o);

  assert_time_steps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (time_q == $past(time_q) + TIME_W'(1)));
endmodule

bind dual_tick_timer dtt_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TIME_W(TIME_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .irq_o   (irq_o),
  .raw_q   (raw_q),
  .mask_q  (mask_q),
  .tmr_exp (tmr_exp),
  .tmr_run (tmr_run),
  .time_q  (time_q)
);

// File: tb/sim_dual_tick_timer.sv
`timescale 1ns/1ps
module sim_dual_tick_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [3:0]  tick_en = '0;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dual_tick_timer u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tick_en(tick_en), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick(input logic [3:0] lanes);
    @(negedge clk);
    tick_en = lanes;
    @(negedge clk);
    tick_en = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  function automatic logic [31:0] cw(input int src, input int op);
    return 32'((src << 2) | op);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, t1, t2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    chk("R12 irq", {31'd0, irq_o}, 0);
    rd(8'h50, v); chk("R12 raw", v, 0);
    rd(8'h40, v); chk("R12 mask", v, 0);
    rd(8'h08, v); chk("R12 count0", v, 0);
    rd(8'h18, v); chk("R12 count1", v, 0);
    rd(8'h04, v); chk("R12 ctrl0", v, 0);
    tick(4'hF);
    rd(8'h50, v); chk("R12 stopped no expiry", v, 0);

    // R3 R4 R6 sweep: every timer, source code and divider 1..4
    for (int t = 0; t < 2; t++) begin
      for (int src = 4; src < 8; src++) begin
        for (int d = 1; d <= 4; d++) begin
          logic [7:0] base;
          logic [3:0] own, others;
          base = 8'(t * 16);
          own = 4'(1 << (src - 4));
          others = ~own;
          wr(8'h44, 3);
          wr(base, 32'(d));
          wr(base + 8'h04, cw(src, 0));
          wr(base + 8'h04, cw(src, 2));
          tick(others);
          rd(base + 8'h08, v); chk("R3 other lanes", v, 32'(d));
          for (int k = 1; k < d; k++) tick(own);
          rd(base + 8'h08, v); chk("R4 count one", v, 1);
          rd(8'h50, v); chk("R6 not yet", v & 32'(1 << t), 0);
          tick(own);
          rd(base + 8'h08, v); chk("R4 reload", v, 32'(d));
          rd(8'h50, v); chk("R6 expiry bit", v & 32'(1 << t), 32'(1 << t));
        end
      end
      wr(8'(t * 16) + 8'h04, cw(4, 1));
    end

    // R3 codes 0..3 never advance
    for (int c = 0; c < 4; c++) begin
      wr(8'h00, 3);
      wr(8'h04, cw(c, 0));
      wr(8'h04, cw(c, 2));
      tick(4'hF);
      rd(8'h08, v); chk("R3 dead source", v, 3);
    end

    // R4 divider 0 expires every tick
    wr(8'h44, 3);
    wr(8'h00, 0);
    wr(8'h04, cw(4, 0));
    wr(8'h04, cw(4, 2));
    tick(4'h1);
    rd(8'h50, v); chk("R4 zero divider expiry", v & 1, 1);
    rd(8'h08, v); chk("R4 zero divider count", v, 0);

    // R1 R2 R5 operation sequence on timer 0
    wr(8'h00, 5);
    wr(8'h04, cw(4, 0));
    rd(8'h08, v); chk("R1 load", v, 5);
    tick(4'h1);
    rd(8'h08, v); chk("R1 load stops", v, 5);
    wr(8'h04, cw(4, 2));
    tick(4'h1); tick(4'h1);
    rd(8'h08, v); chk("R1 run", v, 3);
    wr(8'h04, cw(5, 3));
    rd(8'h04, v); chk("R2 ctrl kept", v, cw(4, 2));
    tick(4'h1);
    rd(8'h08, v); chk("R2 still running on lane0", v, 2);
    wr(8'h00, 9);
    rd(8'h08, v); chk("R5 divider write no effect", v, 2);
    tick(4'h1); tick(4'h1);
    rd(8'h08, v); chk("R5 reload old divider", v, 5);
    wr(8'h04, cw(4, 1));
    tick(4'h1);
    rd(8'h08, v); chk("R1 hold", v, 5);
    wr(8'h04, cw(4, 2));
    for (int k = 0; k < 5; k++) tick(4'h1);
    rd(8'h08, v); chk("R5 new divider active", v, 9);
    wr(8'h04, cw(4, 1));

    // R7 R9 mask and masked status
    wr(8'h14, cw(5, 1));
    wr(8'h44, 3);
    wr(8'h40, 0);
    wr(8'h00, 0);
    wr(8'h04, cw(4, 0));
    wr(8'h04, cw(4, 2));
    tick(4'h1);
    wr(8'h04, cw(4, 1));
    rd(8'h50, v); chk("R6 raw t0", v, 1);
    rd(8'h54, v); chk("R7 masked none", v, 0);
    chk("R9 irq masked off", {31'd0, irq_o}, 0);
    wr(8'h40, 1);
    rd(8'h54, v); chk("R7 masked t0", v, 1);
    chk("R9 irq on", {31'd0, irq_o}, 1);
    wr(8'h40, 2);
    chk("R9 irq off other mask", {31'd0, irq_o}, 0);
    wr(8'h10, 0);
    wr(8'h14, cw(5, 0));
    wr(8'h14, cw(5, 2));
    tick(4'h2);
    rd(8'h50, v); chk("R6 raw both", v, 3);
    rd(8'h54, v); chk("R7 masked t1", v, 2);
    chk("R9 irq t1", {31'd0, irq_o}, 1);

    // R8 acknowledge
    wr(8'h44, 2);
    rd(8'h50, v); chk("R8 ack bit1 only", v, 1);
    chk("R9 irq after ack", {31'd0, irq_o}, 0);
    rd(8'h44, v); chk("R8 ack reads zero", v, 0);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 8'h44; wr_data = 2; tick_en = 4'h2;
    @(negedge clk);
    wr_en = 1'b0; tick_en = '0;
    rd(8'h50, v); chk("R8 set wins", v, 3);
    wr(8'h44, 3);
    rd(8'h50, v); chk("R8 ack all", v, 0);

    // R11 unused offsets
    wr(8'h30, 32'hFFFF_FFFF);
    wr(8'h24, 32'hFFFF_FFFF);
    rd(8'h40, v); chk("R11 mask untouched", v, 2);
    rd(8'h30, v); chk("R11 unused read", v, 0);
    rd(8'h3C, v); chk("R11 unused read 2", v, 0);

    // R10 time register
    rd(8'h20, t1);
    repeat (10) @(negedge clk);
    rd(8'h20, t2);
    chk("R10 time advance", t2 - t1, 10);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule